// File: doc/BRIEF.md
# Dual-Mode Parallel Host Register Port

This block is a byte-wide parallel bus slave that lets a host processor read and write a bank of 8-bit configuration registers. A strap input, sampled while reset is held, picks one of two bus styles. In the separate style, a 7-bit address bus and an 8-bit data bus are used. In the shared style, one 8-bit bus first carries the address, which is captured while the address-latch strobe is high, and then carries the data. Chip select and active-low read and write strobes frame every access. A write takes effect when the write strobe returns high, after that strobe has been brought into the core clock domain. Read data is driven combinationally while chip select and the read strobe are both low.

There are two ways to address the bank. After reset the port is in indirect mode, and only address bit 0 is decoded. With bit 0 at 0 the host reaches a pointer register. With bit 0 at 1 it reaches the bank entry that the pointer names. The pointer holds its value, so the host can make repeated data accesses without setting it again. Bit 0 of a mode register at a fixed address selects direct mode. The host sets that bit through the indirect path. In direct mode every presented address names its bank entry directly. Clearing the mode bit returns the port to indirect mode.

Top module: `hostreg_port`

## Requirements
- R1: After reset every register is 0x00, the pointer is 0, the port is in indirect mode and the drive enable `dq_oe` is low.
- R2: `dq_oe` is high only while `cs_n` and `rd_n` are both low. While `dq_oe` is low, `dq_o` reads 0x00.
- R3: A write commits on the rising edge of `wr_n`, taken after SYNC_STAGES synchronising flops, provided `cs_n` is still low at that point. A write strobe with `cs_n` high changes nothing.
- R4: In indirect mode, a write with address bit 0 = 0 loads the pointer from `dq_i[6:0]`. A read with bit 0 = 0 returns the pointer zero-extended to 8 bits.
- R5: In indirect mode, a write or read with address bit 0 = 1 reaches the bank entry named by the pointer. Address bits 6..1 are ignored.
- R6: The pointer keeps its value across data accesses until it is written again.
- R7: The mode register is at address 0x3B and its bit 0 is the direct-mode flag. Writing 1 to that bit through the indirect path switches the port to direct mode. The stored value reads back.
- R8: In direct mode the 7-bit address selects the bank entry directly. Writing 0 to mode bit 0 returns the port to indirect mode.
- R9: Addresses 96 to 127 are unimplemented. Reads of them return 0x00 and writes to them are dropped.
- R10: With the strap high during reset, the port uses the shared bus. `dq_i[6:0]` is captured as the address on every clock while `ale` is high and is held once `ale` falls. `addr_i` is ignored.
- R11: With the strap low during reset, `addr_i` is the address and `ale` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; async for state, strap sampled while low |
| bus_mux_i | input | 1 | Strap: 1 = shared address/data bus |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ale | input | 1 | Address latch strobe (shared bus only) |
| addr_i | input | 7 | Address (separate bus only) |
| dq_i | input | 8 | Write data; address phase on the shared bus |
| dq_o | output | 8 | Read data |
| dq_oe | output | 1 | Drive enable for `dq_o` |

## Verification
The assertions assume that the strap does not change outside reset. They also assume that the host holds `cs_n`, the address and the write data steady from the fall of `wr_n` until the synchronised rising edge has committed. The bench tasks meet this by keeping chip select and data in place for four clocks after the write strobe rises. They keep `ale` high for two clocks, and they never overlap the read and write strobes. Random addresses, data and operation kinds are drawn only inside these access shapes, so every assumption holds in both bus styles.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
   timeunit 1ns; timeprecision 100ps;

   // Meaning of address bit 0 in indirect mode
   typedef enum logic {
      VSEL_POINTER = 1'b0,
      VSEL_DATA    = 1'b1
   } vsel_e;

   // True when an index falls inside the implemented part of the map
   function automatic logic idx_in_map(input int unsigned idx, input int unsigned count);
      return idx < count;
   endfunction
endpackage

// File: rtl/hostreg_strobe_sync.sv
module hostreg_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n_i,
   output logic rise_o
);
   timeunit 1ns; timeprecision 100ps;

   // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   generate
      if (STAGES < 1) begin : g_bad
         $error("STAGES must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[i] <= 1'b1;
            else if (i == 0) chain[i] <= strobe_n_i;
            else             chain[i] <= chain[(i == 0) ? 0 : i - 1];
         end
      end
   endgenerate

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/hostreg_addr_path.sv
module hostreg_addr_path #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_i,
   input  logic              ale_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] ad_i,
   output logic              mux_o,
   output logic [ADDR_W-1:0] lat_o,
   output logic [ADDR_W-1:0] addr_o
);
   timeunit 1ns; timeprecision 100ps;

   logic              mux_q;
   logic [ADDR_W-1:0] lat_q;

   // Bus style strap: loaded on every clock while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) mux_q <= strap_i;
   end

   // Shared-bus address latch follows the bus while the latch strobe is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lat_q <= '0;
      else if (mux_q && ale_i) lat_q <= ad_i[ADDR_W-1:0];
   end

   assign mux_o  = mux_q;
   assign lat_o  = lat_q;
   assign addr_o = mux_q ? lat_q : addr_i;
endmodule

// File: rtl/hostreg_bank.sv
module hostreg_bank #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = 96,
   parameter int MODE_ADDR = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] mode_o
);
   timeunit 1ns; timeprecision 100ps;
   import hostreg_pkg::*;

   logic [DATA_W-1:0] regs [REG_COUNT];

   generate
      for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
         localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         regs[i] <= '0;
            else if (we_i && waddr_i == MY_ADDR) regs[i] <= wdata_i;
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < REG_COUNT; i++) begin
         if (raddr_i == ADDR_W'(i)) rdata_o = regs[i];
      end
   end

   assign mode_o = idx_in_map(MODE_ADDR, REG_COUNT) ? regs[MODE_ADDR] : '0;
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int REG_COUNT   = 96,
   parameter int MODE_ADDR   = 59,
   parameter int DIRECT_BIT  = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_mux_i,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              ale,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe
);
   timeunit 1ns; timeprecision 100ps;
   import hostreg_pkg::*;

   localparam int PAD_W = DATA_W - ADDR_W;

   generate
      if (DATA_W <= ADDR_W)           begin : g_chk_w  $error("DATA_W must exceed ADDR_W"); end
      if (REG_COUNT > (1 << ADDR_W))  begin : g_chk_n  $error("REG_COUNT exceeds address space"); end
      if (MODE_ADDR >= REG_COUNT)     begin : g_chk_m  $error("MODE_ADDR outside implemented map"); end
      if (DIRECT_BIT >= DATA_W)       begin : g_chk_b  $error("DIRECT_BIT outside data width"); end
   endgenerate

   logic              wr_rise, commit, mux_q, direct;
   logic [ADDR_W-1:0] eff_addr, lat_q, ptr_q, tgt_addr;
   logic [DATA_W-1:0] bank_rd, mode_q, rd_val;
   vsel_e             vsel;

   hostreg_strobe_sync #(.STAGES(SYNC_STAGES)) i_wsync (
      .clk(clk), .rst_n(rst_n), .strobe_n_i(wr_n), .rise_o(wr_rise)
   );

   hostreg_addr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_apath (
      .clk(clk), .rst_n(rst_n), .strap_i(bus_mux_i), .ale_i(ale),
      .addr_i(addr_i), .ad_i(dq_i), .mux_o(mux_q), .lat_o(lat_q), .addr_o(eff_addr)
   );

   assign direct   = mode_q[DIRECT_BIT];
   assign vsel     = vsel_e'(eff_addr[0]);
   assign commit   = wr_rise & ~cs_n;
   assign tgt_addr = direct ? eff_addr : ptr_q;

   // Indirect pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       ptr_q <= '0;
      else if (commit && !direct && vsel == VSEL_POINTER) ptr_q <= dq_i[ADDR_W-1:0];
   end

   hostreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT),
                  .MODE_ADDR(MODE_ADDR)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .we_i(commit && (direct || vsel == VSEL_DATA)),
      .waddr_i(tgt_addr), .wdata_i(dq_i),
      .raddr_i(tgt_addr), .rdata_o(bank_rd), .mode_o(mode_q)
   );

   assign rd_val = (!direct && vsel == VSEL_POINTER) ? {{PAD_W{1'b0}}, ptr_q} : bank_rd;
   assign dq_oe  = ~cs_n & ~rd_n;
   assign dq_o   = dq_oe ? rd_val : '0;
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = 96
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              rd_n,
   input logic              ale,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_o,
   input logic              commit,
   input logic              direct,
   input logic              mux_q,
   input logic [ADDR_W-1:0] lat_q,
   input logic [ADDR_W-1:0] ptr_q,
   input logic [ADDR_W-1:0] eff_addr,
   input logic [DATA_W-1:0] mode_q
);
   timeunit 1ns; timeprecision 100ps;

   localparam logic [ADDR_W:0] CNT_L = (ADDR_W+1)'(REG_COUNT);

   // R2
   oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n || cs_n) |-> (!dq_oe && dq_o == '0));

   // R6
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(ptr_q));

   // R3
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(mode_q));

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && direct && {1'b0, eff_addr} >= CNT_L) |-> dq_o == '0);

   // R10
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> $stable(lat_q));

   // R10
   strap_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(mux_q));
endmodule

bind hostreg_port hostreg_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) i_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .ale(ale), .dq_oe(dq_oe), .dq_o(dq_o),
   .commit(commit), .direct(direct), .mux_q(mux_q), .lat_q(lat_q), .ptr_q(ptr_q),
   .eff_addr(eff_addr), .mode_q(mode_q)
);

// File: tb/test_hostreg_port.sv
module test_hostreg_port;
   timeunit 1ns; timeprecision 100ps;

   localparam int MODE_A = 59;
   localparam int NREG   = 96;

   logic       clk = 0, rst_n = 0, bus_mux_i = 0;
   logic       cs_n = 1, rd_n = 1, wr_n = 1, ale = 0;
   logic [6:0] addr_i = '0;
   logic [7:0] dq_i = '0, dq_o;
   logic       dq_oe;

   int errors = 0, checks = 0, cycles = 0;

   // bench model
   logic [7:0] mem [128];
   logic [6:0] m_ptr;
   logic       m_direct, m_mux;

   hostreg_port i_hostreg_port (
      .clk(clk), .rst_n(rst_n), .bus_mux_i(bus_mux_i), .cs_n(cs_n), .rd_n(rd_n),
      .wr_n(wr_n), .ale(ale), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [6:0] a);
      logic [6:0] t;
      if (!m_direct && a[0] == 1'b0) return {1'b0, m_ptr};
      t = m_direct ? a : m_ptr;
      return (t < NREG) ? mem[t] : 8'h00;
   endfunction

   function automatic void model_write(input logic [6:0] a, input logic [7:0] d);
      logic [6:0] t;
      if (!m_direct && a[0] == 1'b0) begin m_ptr = d[6:0]; return; end
      t = m_direct ? a : m_ptr;
      if (t < NREG) mem[t] = d;
      m_direct = mem[MODE_A][0];
   endfunction

   task automatic do_reset(input logic strap);
      rst_n = 0; bus_mux_i = strap; cs_n = 1; rd_n = 1; wr_n = 1; ale = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      bus_mux_i = ~strap;   // strap must not matter after reset
      for (int i = 0; i < 128; i++) mem[i] = 8'h00;
      m_ptr = '0; m_direct = 0; m_mux = strap;
      @(negedge clk);
   endtask

   // address phase; in separate-bus mode the ale pulse carries garbage (R11)
   task automatic addr_phase(input logic [6:0] a);
      if (m_mux) begin
         addr_i = 7'($urandom);
         dq_i = {1'b0, a}; ale = 1;
         repeat (2) @(negedge clk);
         ale = 0;
         @(negedge clk);
      end else begin
         addr_i = a;
         dq_i = 8'($urandom); ale = 1;
         repeat (2) @(negedge clk);
         ale = 0;
         @(negedge clk);
      end
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [7:0] d, input logic sel = 1);
      @(negedge clk);
      addr_phase(a);
      dq_i = d; cs_n = ~sel;
      @(negedge clk); wr_n = 0;
      repeat (2) @(negedge clk); wr_n = 1;
      repeat (4) @(negedge clk); cs_n = 1;
      @(negedge clk);
      if (sel) model_write(a, d);
   endtask

   task automatic bus_read(input string req, input logic [6:0] a);
      logic [7:0] v;
      @(negedge clk);
      addr_phase(a);
      dq_i = 8'($urandom);   // host has released the shared bus
      cs_n = 0; rd_n = 0;
      @(negedge clk);
      v = dq_o;
      chk({req, " oe"}, {7'b0, dq_oe}, 8'h01);
      chk(req, v, exp_read(a));
      rd_n = 1; cs_n = 1;
      @(negedge clk);
   endtask

   task automatic random_ops(input int n);
      for (int i = 0; i < n; i++) begin
         logic [6:0] a;
         int k;
         a = 7'($urandom_range(0, 127));
         k = $urandom_range(0, 9);
         if (a == MODE_A && k < 5) continue;
         if (k < 5) bus_write(a, 8'($urandom));
         else       bus_read(m_direct ? "R8 random" : "R5 random", a);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));

      // separate bus
      do_reset(1'b0);
      chk("R1 oe idle", {7'b0, dq_oe}, 8'h00);
      bus_read("R1 pointer", 7'h00);
      bus_read("R1 data", 7'h01);

      // R2: strobes alone do not drive
      cs_n = 0; @(negedge clk);
      chk("R2 cs only", {7'b0, dq_oe}, 8'h00);
      chk("R2 cs only dq", dq_o, 8'h00);
      cs_n = 1; rd_n = 0; @(negedge clk);
      chk("R2 rd only", {7'b0, dq_oe}, 8'h00);
      rd_n = 1; @(negedge clk);

      bus_write(7'h00, 8'h10);
      bus_read("R4 pointer", 7'h00);
      bus_write(7'h01, 8'hA5);
      bus_read("R5 data", 7'h01);
      bus_write(7'h7E, 8'h22);           // high bits ignored: pointer write
      bus_read("R5 hi bits ptr", 7'h40);
      bus_write(7'h35, 8'h11);           // odd address: data write to 0x22
      bus_read("R6 first", 7'h01);
      bus_read("R6 second", 7'h0F);
      bus_read("R6 ptr kept", 7'h00);

      bus_write(7'h01, 8'hEE, 1'b0);     // R3: chip select high, ignored
      bus_read("R3 ignored", 7'h01);

      bus_write(7'h00, 8'h70);
      bus_write(7'h01, 8'h55);
      bus_read("R9 indirect", 7'h01);

      bus_write(7'h00, 8'(MODE_A));
      bus_write(7'h01, 8'h01);           // R7 switch to direct
      bus_read("R7 mode", 7'(MODE_A));
      bus_read("R8 direct", 7'h10);
      bus_read("R8 direct b", 7'h22);
      bus_write(7'h65, 8'h77);
      bus_read("R9 direct", 7'h65);

      random_ops(150);

      if (!m_direct) begin
         bus_write(7'h00, 8'(MODE_A));
         bus_write(7'h01, 8'h01);
      end
      bus_write(7'(MODE_A), 8'h00);      // R8 back to indirect
      bus_read("R8 indirect again", 7'h00);

      // shared bus
      do_reset(1'b1);
      bus_read("R1 mux reset", 7'h01);
      bus_write(7'h00, 8'h05);
      bus_write(7'h01, 8'h3C);
      bus_read("R10 mux ptr", 7'h00);
      bus_read("R10 mux data", 7'h01);
      bus_write(7'h00, 8'(MODE_A));
      bus_write(7'h01, 8'h01);
      bus_write(7'h2A, 8'h9D);
      bus_read("R10 mux direct", 7'h2A);
      bus_read("R10 mux direct b", 7'h05);
      random_ops(150);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule